// File: doc/BRIEF.md
# Call/return frame sequencer

This block carries out the stack-frame work of a subroutine call or return as a short multi-cycle sequence. The frame pointer (register 0) and the stack pointer (register 1) come in with the request. The block performs two 32-bit transfers on a memory port that uses a request/acknowledge handshake. When it finishes, it presents the updated pointers and the next program counter, together with a one-cycle `done` pulse.

Each call sets aside two words below the stack pointer. The lower of the two holds the return address and the upper one is a static-chain slot. The old frame pointer is then pushed below them, and the frame pointer ends up equal to the new stack pointer. A return does the reverse. It walks back through the frame pointer, restores the saved frame pointer and return address, and steps the stack pointer past the static-chain slot. Requests arrive on a valid/ready interface. `req_ready` is high only while the sequencer is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. An upstream stage facing a low `req_ready` keeps its request and its operands steady until it is accepted.

Top module: `frame_seq`

## Requirements
- R1: `req_ready` is high only in the idle state. It drops in the cycle after a request is accepted and stays low until the cycle after `done`.
- R2: A call with `req_op` = 2'b00 (absolute call carrying a 32-bit literal) writes the return address `req_pc + 6` as its first memory access, at byte address `req_sp - 8`.
- R3: A call with `req_op` = 2'b01 (register-indirect call) writes the return address `req_pc + 2` as its first memory access, at byte address `req_sp - 8`.
- R4: The second memory access of either call writes the old `req_fp` at byte address `req_sp - 12`.
- R5: When a call completes, `new_fp` = `new_sp` = `req_sp - 12` and `new_pc` = `req_target`.
- R6: A return (`req_op` = 2'b10) first reads the word at `req_fp`, then reads the word at `req_fp + 4`. When it completes, `new_fp` is the first word read, `new_pc` is the second word read and `new_sp` = `req_fp + 12`. `mem_we` stays low for both reads.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. No access starts before the previous access has been acknowledged, and `mem_req` is low whenever the block is idle.
- R8: `done` lasts exactly one cycle. `new_fp`, `new_sp` and `new_pc` change only in the cycle in which `done` is high.
- R9: The reserved code `req_op` = 2'b11 completes with `done` in the cycle after acceptance and makes no memory access. It returns `new_fp` = `req_fp`, `new_sp` = `req_sp` and `new_pc` = `req_pc`.
- R10: After reset the block is idle: `req_ready` = 1, `done` = 0, `mem_req` = 0, and all three result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_op | input | 2 | 00 absolute call, 01 register call, 10 return, 11 reserved |
| req_pc | input | 32 | PC of the call instruction |
| req_target | input | 32 | Call destination |
| req_fp | input | 32 | Current frame pointer |
| req_sp | input | 32 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |
| new_fp | output | 32 | Updated frame pointer |
| new_sp | output | 32 | Updated stack pointer |
| new_pc | output | 32 | Next program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data is valid in this cycle |
| mem_rdata | input | 32 | Read data |

## Verification
The bench builds the block with its defaults: 32-bit data, a 2-byte instruction and a 4-byte call literal. These defaults make the two distinct return-address offsets (+6 and +2) and the 8-byte slot plus 4-byte frame word directly observable. Its memory model acknowledges each access after zero to three wait cycles, which exercises the hold-until-acknowledge rule. Call/return pairs and a nested pair check that a return undoes exactly what its call stored.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'b00,
    OP_CALL_REG = 2'b01,
    OP_RET      = 2'b10,
    OP_NONE     = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC1 = 2'd1,
    ST_ACC2 = 2'd2,
    ST_FIN  = 2'd3
  } st_e;
endpackage

// File: rtl/frame_seq_fsm.sv
module frame_seq_fsm
  import frame_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  op_e  req_op,
  input  logic mem_ack,
  output logic req_ready,
  output logic accept,
  output logic mem_req,
  output logic mem_we,
  output logic second,
  output logic done,
  output logic fin_ld,
  output op_e  op_q
);
  st_e state, state_nx;

  always_comb begin
    req_ready = (state == ST_IDLE);
    accept    = req_valid && req_ready;
    mem_req   = (state == ST_ACC1) || (state == ST_ACC2);
    mem_we    = mem_req && (op_q != OP_RET);
    second    = (state == ST_ACC2);
    done      = (state == ST_FIN);
    fin_ld    = (accept && req_op == OP_NONE) || (second && mem_ack);
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (accept) state_nx = (req_op == OP_NONE) ? ST_FIN : ST_ACC1;
      ST_ACC1: if (mem_ack) state_nx = ST_ACC2;
      ST_ACC2: if (mem_ack) state_nx = ST_FIN;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_NONE;
    end else begin
      state <= state_nx;
      if (accept) op_q <= req_op;
    end
  end

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  none_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op == OP_NONE) |=> (done && !mem_req));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);
endmodule

// File: rtl/frame_seq_dp.sv
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int INSN_BYTES = 2,
  parameter int LIT_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_target,
  input  logic [DATA_W-1:0] req_fp,
  input  logic [DATA_W-1:0] req_sp,
  input  op_e               op_q,
  input  logic              mem_req,
  input  logic              mem_ack,
  input  logic              second,
  input  logic              fin_ld,
  input  logic              done,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] new_fp,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_pc
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] WORD_C   = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] SLOT_C   = DATA_W'(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] RA_ABS_C = DATA_W'(INSN_BYTES + LIT_BYTES);
  localparam logic [DATA_W-1:0] RA_REG_C = DATA_W'(INSN_BYTES);

  logic [DATA_W-1:0] pc_q, tgt_q, fp_q, sp_q, rd1_q;
  logic [DATA_W-1:0] frame_base;

  assign frame_base = sp_q - SLOT_C - WORD_C;

  always_comb begin
    if (op_q == OP_RET) begin
      mem_addr  = second ? (fp_q + WORD_C) : fp_q;
      mem_wdata = '0;
    end else begin
      mem_addr  = second ? frame_base : (sp_q - SLOT_C);
      mem_wdata = second ? fp_q
                         : pc_q + ((op_q == OP_CALL_ABS) ? RA_ABS_C : RA_REG_C);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      tgt_q  <= '0;
      fp_q   <= '0;
      sp_q   <= '0;
      rd1_q  <= '0;
      new_fp <= '0;
      new_sp <= '0;
      new_pc <= '0;
    end else begin
      if (accept) begin
        pc_q  <= req_pc;
        tgt_q <= req_target;
        fp_q  <= req_fp;
        sp_q  <= req_sp;
      end
      if (mem_req && mem_ack && !second) rd1_q <= mem_rdata;
      if (fin_ld) begin
        if (accept) begin
          new_fp <= req_fp;
          new_sp <= req_sp;
          new_pc <= req_pc;
        end else if (op_q == OP_RET) begin
          new_fp <= rd1_q;
          new_sp <= fp_q + WORD_C + SLOT_C;
          new_pc <= mem_rdata;
        end else begin
          new_fp <= frame_base;
          new_sp <= frame_base;
          new_pc <= tgt_q;
        end
      end
    end
  end

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));
  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_fp) && $stable(new_sp) && $stable(new_pc)));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import frame_seq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int INSN_BYTES = 2,
  parameter int LIT_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [DATA_W-1:0] req_pc,
  input  logic [DATA_W-1:0] req_target,
  input  logic [DATA_W-1:0] req_fp,
  input  logic [DATA_W-1:0] req_sp,
  output logic              done,
  output logic [DATA_W-1:0] new_fp,
  output logic [DATA_W-1:0] new_sp,
  output logic [DATA_W-1:0] new_pc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  op_e  op_in, op_q;
  logic accept, second, fin_ld;

  assign op_in = op_e'(req_op);

  frame_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_in),
    .mem_ack(mem_ack), .req_ready(req_ready), .accept(accept),
    .mem_req(mem_req), .mem_we(mem_we), .second(second), .done(done),
    .fin_ld(fin_ld), .op_q(op_q)
  );

  frame_seq_dp #(
    .DATA_W(DATA_W), .INSN_BYTES(INSN_BYTES), .LIT_BYTES(LIT_BYTES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_pc(req_pc),
    .req_target(req_target), .req_fp(req_fp), .req_sp(req_sp),
    .op_q(op_q), .mem_req(mem_req), .mem_ack(mem_ack), .second(second),
    .fin_ld(fin_ld), .done(done), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .new_fp(new_fp), .new_sp(new_sp), .new_pc(new_pc)
  );
endmodule

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [31:0] req_pc = '0, req_target = '0, req_fp = '0, req_sp = '0;
  logic        done;
  logic [31:0] new_fp, new_sp, new_pc;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int errors = 0;
  int checks = 0;

  typedef struct { logic [31:0] fp; logic [31:0] sp; logic [31:0] pc; } res_t;
  typedef struct { logic we; logic [31:0] addr; logic [31:0] data; string req; } acc_t;
  res_t exp_res[$];
  acc_t exp_acc[$];

  logic [31:0] mem [0:255];
  logic [31:0] shadow [0:255];
  int lat_cnt = 0;
  int lat_seed = 0;

  always #4 clk = ~clk;

  frame_seq u_frame_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_pc(req_pc), .req_target(req_target),
    .req_fp(req_fp), .req_sp(req_sp), .done(done), .new_fp(new_fp),
    .new_sp(new_sp), .new_pc(new_pc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model with 0..3 wait cycles
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        lat_seed = lat_seed + 1;
        lat_cnt  = (lat_seed * 3) % 4;
      end else begin
        lat_cnt = lat_cnt - 1;
      end
    end
  end

  // monitor: memory accesses
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (exp_acc.size() == 0) begin
        chk(1'b0, "R9 unexpected access", mem_addr, 32'h0);
      end else begin
        acc_t e;
        e = exp_acc.pop_front();
        chk(mem_we == e.we, {e.req, " we"}, {31'h0, mem_we}, {31'h0, e.we});
        chk(mem_addr == e.addr, {e.req, " addr"}, mem_addr, e.addr);
        if (e.we) chk(mem_wdata == e.data, {e.req, " wdata"}, mem_wdata, e.data);
      end
    end
  end

  // monitor: results
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_res.size() == 0) begin
        chk(1'b0, "R8 unexpected done", new_pc, 32'h0);
      end else begin
        res_t e;
        e = exp_res.pop_front();
        chk(new_fp == e.fp, "R5/R6/R9 new_fp", new_fp, e.fp);
        chk(new_sp == e.sp, "R5/R6/R9 new_sp", new_sp, e.sp);
        chk(new_pc == e.pc, "R5/R6/R9 new_pc", new_pc, e.pc);
      end
    end
  end

  task automatic preload(input logic [31:0] addr, input logic [31:0] val);
    mem[addr[9:2]]    = val;
    shadow[addr[9:2]] = val;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [31:0] pc,
                        input logic [31:0] tgt, input logic [31:0] fp,
                        input logic [31:0] sp);
    res_t r;
    acc_t a;
    logic [31:0] base;
    base = sp - 32'd12;
    case (op)
      2'b00, 2'b01: begin
        a.we = 1'b1; a.addr = sp - 32'd8;
        a.data = pc + ((op == 2'b00) ? 32'd6 : 32'd2);
        a.req = (op == 2'b00) ? "R2" : "R3";
        exp_acc.push_back(a);
        shadow[a.addr[9:2]] = a.data;
        a.we = 1'b1; a.addr = base; a.data = fp; a.req = "R4";
        exp_acc.push_back(a);
        shadow[base[9:2]] = fp;
        r.fp = base; r.sp = base; r.pc = tgt;
      end
      2'b10: begin
        a.we = 1'b0; a.addr = fp; a.data = '0; a.req = "R6";
        exp_acc.push_back(a);
        a.addr = fp + 32'd4;
        exp_acc.push_back(a);
        r.fp = shadow[fp[9:2]];
        r.pc = shadow[(fp[9:2]) + 8'd1];
        r.sp = fp + 32'd12;
      end
      default: begin
        r.fp = fp; r.sp = sp; r.pc = pc;
      end
    endcase
    exp_res.push_back(r);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready while idle", {31'h0, req_ready}, 32'h1);
    req_valid = 1'b1; req_op = op; req_pc = pc; req_target = tgt;
    req_fp = fp; req_sp = sp;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low when busy", {31'h0, req_ready}, 32'h0);
    if (op == 2'b11)
      chk(done == 1'b1, "R9 done next cycle", {31'h0, done}, 32'h1);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", {31'h0, done}, 32'h0);
    chk(new_sp == r.sp, "R8 outputs held", new_sp, r.sp);
    chk(req_ready == 1'b1, "R1 ready after done", {31'h0, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready", {31'h0, req_ready}, 32'h1);
    chk(done == 1'b0, "R10 done", {31'h0, done}, 32'h0);
    chk(mem_req == 1'b0, "R10 mem_req", {31'h0, mem_req}, 32'h0);
    chk(new_pc == 32'h0, "R10 new_pc", new_pc, 32'h0);
    chk(new_sp == 32'h0, "R10 new_sp", new_sp, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0, "R7 idle quiet", {31'h0, mem_req}, 32'h0);
    // R2/R4/R5 absolute call, then R6 return undoing it
    run_op(2'b00, 32'h0000_1000, 32'h0000_4000, 32'h0000_0300, 32'h0000_0200);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_01F4, 32'h0000_01F4);
    // R3 register call and its return
    run_op(2'b01, 32'h0000_2222, 32'hABCD_0000, 32'h0000_0111, 32'h0000_0100);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_00F4, 32'h0000_00F4);
    // R9 reserved op: no access, pass-through
    run_op(2'b11, 32'h0000_0055, 32'h9999_9999, 32'h0000_0066, 32'h0000_0077);
    // R6 return from a preloaded frame
    preload(32'h0000_0080, 32'hDEAD_0000);
    preload(32'h0000_0084, 32'h1234_5678);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_0080, 32'h0000_0080);
    // nested calls then returns
    run_op(2'b00, 32'h0000_3000, 32'h0000_5000, 32'h0000_03F0, 32'h0000_0380);
    run_op(2'b01, 32'h0000_5010, 32'h0000_6000, 32'h0000_0374, 32'h0000_0374);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_0368, 32'h0000_0368);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_0374, 32'h0000_0374);
    repeat (3) @(negedge clk);
    chk(exp_acc.size() == 0, "R7 all accesses seen", exp_acc.size(), 32'h0);
    chk(exp_res.size() == 0, "R8 all results seen", exp_res.size(), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule